// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Gate

This block decides, for each of nineteen reference-clock outputs, whether the output passes the clock or sits in high impedance. Each output has an enable condition with two parts. The first is an active-low enable pin. Some pins serve one output, and others serve a group of outputs. The second is an enable bit from the control register. A power-good input overrides both. While this input is low, every output is parked. When it rises, the strap inputs are captured and a programmable settling delay starts before any output is released.

All enable inputs are asynchronous to the clock, so each one passes through a synchroniser in the clock domain. The final gate flop for each output changes only on the falling clock edge. A started or stopped output therefore never shows a shortened high pulse. The tri-state control of each output is modelled as an enable flag. That flag also serves as the status of which outputs are running.

Top module: `diffclk_oe_gate`

## Requirements
- R1: An output is enabled only when its enable pin is low and its register enable bit `reg_en[i]` is 1. If either condition fails, its `out_oe[i]` is 0 and its `out_clk[i]` stays low.
- R2: Pin `oe_g0_n` serves outputs 0 to 4, `oe_g1_n` serves outputs 15 and 16, and `oe_g2_n` serves outputs 17 and 18. Bit `oe_solo_n[j]` serves output 5+j alone, for j from 0 to 9.
- R3: While reset is asserted, `out_oe` is all zeros, `out_clk` is all zeros and `strap_q` is zero.
- R4: After an output's enable condition becomes true, the output delivers its first clock high phase within 4 to 12 rising clock edges.
- R5: After an output's enable condition becomes false, its `out_oe` falls within 4 to 12 rising clock edges. `out_oe` only ever changes while `clk_in` is low.
- R6: When `pwr_ok` is low, every output is disabled within 4 to 12 rising edges and stays disabled while `pwr_ok` remains low.
- R7: A synchronised rising edge of `pwr_ok` loads `strap_in` into `strap_q` (bits 2..0 are the address straps and bit 3 is the bypass strap). At any other time, changes on `strap_in` do not affect `strap_q`.
- R8: After `pwr_ok` rises with `hold_cycles` = H, the first output high phase occurs on rising edge 5+H, counted from the first rising edge after the rise.
- R9: While `out_oe[i]` is 1, `out_clk[i]` follows `clk_in`. While it is 0, `out_clk[i]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock, also the domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good; low requests power-down |
| oe_g0_n | input | 1 | Active-low enable, outputs 0-4 |
| oe_solo_n | input | 10 | Active-low enables, bit j for output 5+j |
| oe_g1_n | input | 1 | Active-low enable, outputs 15-16 |
| oe_g2_n | input | 1 | Active-low enable, outputs 17-18 |
| reg_en | input | 19 | Per-output register enable bits |
| strap_in | input | 4 | Strap pins: address [2:0], bypass [3] |
| hold_cycles | input | 8 | Settling delay after power-up, in clock cycles |
| out_clk | output | 19 | Gated clock per output |
| out_oe | output | 19 | Per-output drive enable / running status |
| strap_q | output | 4 | Straps captured at power-up |

## Verification
Four properties are checked on every cycle. `out_oe` only moves while the clock is low. The gated clock matches the enable flag during the high phase. A register bit held clear for four edges forces its output off. A power-good held low for four edges forces every output off. Other behaviours need a scenario to reveal them: the exact start and stop latencies, the mapping of group pins onto outputs, the settling count after power-up, and the one-time capture of the straps.

// File: rtl/diffclk_oe_pkg.sv
package diffclk_oe_pkg;
  localparam int N_OUT  = 19;
  localparam int N_SOLO = 10;
  localparam int N_PIN  = N_SOLO + 3;
  localparam int SOLO_BASE = 5;

  // pin vector layout: [0] group 0-4, [1..10] solo 5..14, [11] group 15-16, [12] group 17-18
  function automatic int pin_of(input int o);
    if (o < SOLO_BASE)               return 0;
    else if (o < SOLO_BASE + N_SOLO) return o - SOLO_BASE + 1;
    else if (o < 17)                 return N_SOLO + 1;
    else                             return N_SOLO + 2;
  endfunction
endpackage

// File: rtl/diffclk_rst_sync.sv
module diffclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end
  assign rst_sn = sh_q[1];
endmodule

// File: rtl/diffclk_sync.sv
module diffclk_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] st_d;
    if (s == 0) begin : g_first
      assign st_d = d;
    end else begin : g_next
      assign st_d = st_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) st_q[s] <= '0;
      else         st_q[s] <= st_d;
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/diffclk_pd_seq.sv
module diffclk_pd_seq #(
  parameter int HOLD_W  = 8,
  parameter int STRAP_W = 4
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               pwr_s,
  input  logic [HOLD_W-1:0]  hold_cycles,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [STRAP_W-1:0] strap_q,
  output logic               run_ok
);
  logic               pwr_d_q;
  logic [HOLD_W-1:0]  cnt_q, cnt_d;
  logic [STRAP_W-1:0] strap_d;
  logic               rise;

  always_comb begin
    rise    = pwr_s & ~pwr_d_q;
    strap_d = strap_q;
    cnt_d   = cnt_q;
    if (rise) begin
      strap_d = strap_in;
      cnt_d   = hold_cycles;
    end else if (!pwr_s) begin
      cnt_d   = '0;
    end else if (cnt_q != '0) begin
      cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pwr_d_q <= 1'b0;
      cnt_q   <= '0;
      strap_q <= '0;
    end else begin
      pwr_d_q <= pwr_s;
      cnt_q   <= cnt_d;
      strap_q <= strap_d;
    end
  end

  assign run_ok = pwr_s & pwr_d_q & (cnt_q == '0);
endmodule

// File: rtl/diffclk_gate.sv
module diffclk_gate #(
  parameter int N = 19
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [N-1:0] want,
  output logic [N-1:0] oe,
  output logic [N-1:0] clk_out
);
  logic [N-1:0] req_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) req_q <= '0;
    else         req_q <= want;
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    logic gate_q;
    // falling-edge update: the gate changes only in the low phase
    always_ff @(negedge clk or negedge rst_sn) begin
      if (!rst_sn) gate_q <= 1'b0;
      else         gate_q <= req_q[i];
    end
    assign oe[i]      = gate_q;
    assign clk_out[i] = clk & gate_q;
  end
endmodule

// File: rtl/diffclk_oe_gate.sv
module diffclk_oe_gate
  import diffclk_oe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_W      = 8,
  parameter int STRAP_W     = 4
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               pwr_ok,
  input  logic               oe_g0_n,
  input  logic [N_SOLO-1:0]  oe_solo_n,
  input  logic               oe_g1_n,
  input  logic               oe_g2_n,
  input  logic [N_OUT-1:0]   reg_en,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic [HOLD_W-1:0]  hold_cycles,
  output logic [N_OUT-1:0]   out_clk,
  output logic [N_OUT-1:0]   out_oe,
  output logic [STRAP_W-1:0] strap_q
);
  localparam int SYNC_W = N_PIN + N_OUT + 1;

  logic               rst_sn;
  logic [N_PIN-1:0]   pin_n;
  logic [SYNC_W-1:0]  sync_q;
  logic [N_PIN-1:0]   pin_s;
  logic [N_OUT-1:0]   reg_s;
  logic               pwr_s;
  logic               run_ok;
  logic [N_OUT-1:0]   want;

  assign pin_n = {oe_g2_n, oe_g1_n, oe_solo_n, oe_g0_n};

  diffclk_rst_sync u_rst (.clk(clk_in), .rst_n(rst_n), .rst_sn(rst_sn));

  diffclk_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_in), .rst_sn(rst_sn),
    .d({pwr_ok, reg_en, pin_n}), .q(sync_q)
  );
  assign pin_s = sync_q[N_PIN-1:0];
  assign reg_s = sync_q[N_PIN +: N_OUT];
  assign pwr_s = sync_q[SYNC_W-1];

  diffclk_pd_seq #(.HOLD_W(HOLD_W), .STRAP_W(STRAP_W)) u_pd (
    .clk(clk_in), .rst_sn(rst_sn), .pwr_s(pwr_s),
    .hold_cycles(hold_cycles), .strap_in(strap_in),
    .strap_q(strap_q), .run_ok(run_ok)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_want
    assign want[i] = ~pin_s[pin_of(i)] & reg_s[i] & run_ok;
  end

  diffclk_gate #(.N(N_OUT)) u_gate (
    .clk(clk_in), .rst_sn(rst_sn), .want(want),
    .oe(out_oe), .clk_out(out_clk)
  );
endmodule

// File: rtl/diffclk_oe_gate_chk.sv
module diffclk_oe_gate_chk #(
  parameter int N = 19
) (
  input logic         clk_in,
  input logic         rst_sn,
  input logic         pwr_ok,
  input logic [N-1:0] reg_en,
  input logic [N-1:0] out_oe,
  input logic [N-1:0] out_clk
);
  // R5
  always @(out_oe) begin
    if (rst_sn === 1'b1) begin
      oe_low_phase_chk: assert (clk_in == 1'b0);
    end
  end

  // R9
  oe_clk_follow_chk: assert property (@(negedge clk_in) disable iff (!rst_sn)
    out_clk == out_oe);

  // R1
  reg_clear_off_chk: assert property (@(posedge clk_in) disable iff (!rst_sn)
    (out_oe & ~reg_en & ~$past(reg_en) & ~$past(reg_en, 2) & ~$past(reg_en, 3)) == '0);

  // R6
  pd_all_off_chk: assert property (@(posedge clk_in) disable iff (!rst_sn)
    (!pwr_ok && !$past(pwr_ok) && !$past(pwr_ok, 2) && !$past(pwr_ok, 3))
      |-> (out_oe == '0));
endmodule

bind diffclk_oe_gate diffclk_oe_gate_chk #(.N(diffclk_oe_pkg::N_OUT)) u_chk (
  .clk_in(clk_in), .rst_sn(rst_sn), .pwr_ok(pwr_ok),
  .reg_en(reg_en), .out_oe(out_oe), .out_clk(out_clk)
);

// File: tb/diffclk_oe_gate_bench.sv
module diffclk_oe_gate_bench;
  logic        clk_in = 1'b0;
  logic        rst_n;
  logic        pwr_ok;
  logic        oe_g0_n, oe_g1_n, oe_g2_n;
  logic [9:0]  oe_solo_n;
  logic [18:0] reg_en;
  logic [3:0]  strap_in;
  logic [7:0]  hold_cycles;
  logic [18:0] out_clk, out_oe;
  logic [3:0]  strap_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_in = ~clk_in;

  diffclk_oe_gate u_diffclk_oe_gate (
    .clk_in(clk_in), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .oe_g0_n(oe_g0_n), .oe_solo_n(oe_solo_n), .oe_g1_n(oe_g1_n), .oe_g2_n(oe_g2_n),
    .reg_en(reg_en), .strap_in(strap_in), .hold_cycles(hold_cycles),
    .out_clk(out_clk), .out_oe(out_oe), .strap_q(strap_q)
  );

  function automatic logic [18:0] model();
    logic [18:0] e;
    for (int i = 0; i < 19; i++) begin
      logic p;
      if (i < 5)       p = oe_g0_n;
      else if (i < 15) p = oe_solo_n[i-5];
      else if (i < 17) p = oe_g1_n;
      else             p = oe_g2_n;
      e[i] = !p && reg_en[i] && pwr_ok;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // count rising edges until out_oe[idx] reaches tgt (sampled 1 ns after each edge)
  task automatic meas(input int idx, input logic tgt, output int n);
    bit got = 0;
    n = 99;
    for (int c = 1; c <= 20 && !got; c++) begin
      @(posedge clk_in); #1;
      if (out_oe[idx] === tgt) begin got = 1; n = c; end
    end
  endtask

  task automatic settle();
    repeat (14) @(posedge clk_in);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; pwr_ok = 0; oe_g0_n = 0; oe_g1_n = 0; oe_g2_n = 0; oe_solo_n = '0;
    reg_en = '1; strap_in = 4'b1010; hold_cycles = 8'd3;
    repeat (3) @(posedge clk_in); #1;
    chk("R3 out_oe in reset", 32'(out_oe), 32'h0);
    chk("R3 out_clk in reset", 32'(out_clk), 32'h0);
    chk("R3 strap_q in reset", 32'(strap_q), 32'h0);
    @(negedge clk_in) rst_n = 1;
    settle();
    chk("R6 outputs off while pwr_ok low", 32'(out_oe), 32'h0);
  endtask

  task automatic t_powerup();
    int n;
    @(negedge clk_in) pwr_ok = 1;
    meas(0, 1'b1, n);
    chk("R8 first start edge with hold=3", 32'(n), 32'd8);
    chk("R1 all outputs on", 32'(out_oe), 32'(19'h7FFFF));
    chk("R7 straps captured", 32'(strap_q), 32'hA);
  endtask

  task automatic t_strap_ignored();
    @(negedge clk_in) strap_in = 4'b0011;
    settle();
    chk("R7 strap change ignored while running", 32'(strap_q), 32'hA);
  endtask

  task automatic t_group(input string nm, input int idx, input int which);
    int n;
    @(negedge clk_in);
    case (which)
      0: oe_g0_n = 1;
      1: oe_g1_n = 1;
      2: oe_g2_n = 1;
      default: oe_solo_n[3] = 1;
    endcase
    meas(idx, 1'b0, n);
    chk_rng({"R5 stop latency ", nm}, n, 4, 12);
    settle();
    chk({"R2 group mask ", nm}, 32'(out_oe), 32'(model()));
    @(negedge clk_in);
    case (which)
      0: oe_g0_n = 0;
      1: oe_g1_n = 0;
      2: oe_g2_n = 0;
      default: oe_solo_n[3] = 0;
    endcase
    meas(idx, 1'b1, n);
    chk_rng({"R4 start latency ", nm}, n, 4, 12);
    settle();
  endtask

  task automatic t_regbit();
    int n;
    @(negedge clk_in) reg_en[10] = 0;
    meas(10, 1'b0, n);
    chk_rng("R5 stop latency reg bit", n, 4, 12);
    @(negedge clk_in) oe_solo_n[5] = 1;
    settle();
    @(negedge clk_in) reg_en[10] = 1;
    settle();
    chk("R1 pin high, reg bit 1 stays off", 32'(out_oe[10]), 32'h0);
    @(negedge clk_in) oe_solo_n[5] = 0;
    meas(10, 1'b1, n);
    chk_rng("R4 start latency pin", n, 4, 12);
    chk("R1 both conditions met", 32'(out_oe), 32'(19'h7FFFF));
  endtask

  task automatic t_clock();
    int hi_ok = 1, lo_ok = 1;
    @(negedge clk_in) reg_en[2] = 0;
    settle();
    for (int c = 0; c < 8; c++) begin
      @(posedge clk_in); #1;
      if (out_clk !== model()) hi_ok = 0;
      @(negedge clk_in); #1;
      if (out_clk !== 19'h0) lo_ok = 0;
    end
    chk("R9 out_clk high phase follows enables", 32'(hi_ok), 32'd1);
    chk("R9 out_clk low in low phase", 32'(lo_ok), 32'd1);
    @(negedge clk_in) reg_en[2] = 1;
    settle();
  endtask

  task automatic t_powerdown();
    int n, quiet = 1;
    @(negedge clk_in) pwr_ok = 0;
    meas(18, 1'b0, n);
    chk_rng("R6 power-down stop latency", n, 4, 12);
    chk("R6 all outputs off", 32'(out_oe), 32'h0);
    @(negedge clk_in) begin strap_in = 4'b0101; hold_cycles = 8'd0; end
    for (int c = 0; c < 8; c++) begin
      @(posedge clk_in); #1;
      if (out_clk !== 19'h0) quiet = 0;
    end
    chk("R6 clock stopped in power-down", 32'(quiet), 32'd1);
    chk("R7 no capture while down", 32'(strap_q), 32'hA);
    @(negedge clk_in) pwr_ok = 1;
    meas(0, 1'b1, n);
    chk("R8 first start edge with hold=0", 32'(n), 32'd5);
    chk("R7 straps recaptured", 32'(strap_q), 32'h5);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_strap_ignored();
    t_group("g0", 0, 0);
    t_group("g1", 15, 1);
    t_group("g2", 17, 2);
    t_group("solo8", 8, 3);
    t_regbit();
    t_clock();
    t_powerdown();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_in);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule